// File: doc/BRIEF.md
# Virtual Address Translator with Translation Cache

This block turns a virtual byte address into a physical byte address. The high part of the address is the virtual page number. It is looked up in a small fully associative translation cache. That cache sits in front of a single-level page map held in internal registers. The low part of the address is the page offset, and it passes through unchanged. A hit in the cache answers without touching the page map.

On a miss, the block spends one extra cycle reading the page map. If the page is resident, the block writes the translation into the cache slot that was least recently used. If the page is not resident, the block returns a page fault instead of an address. A store marks its page dirty.

Software fills the page map through a write port, and a combinational monitor port shows any entry. Requests and responses use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high. A response stays on the pins, unchanged, until `rsp_ready` is seen high with `rsp_valid`. While a response is stalled, `req_ready` is low, so the block accepts no new work. Only one translation is in flight at a time.

Top module: `vm_xlate`

## Requirements
- R1: `rsp_paddr` is the physical page number in the high `PPN_W` bits, with the request's low `OFS_W` offset bits copied unchanged below it. With the defaults (3-bit page number in, 2-bit page number out, 4-bit offset), a 7-bit virtual address becomes a 6-bit physical address.
- R2: When the virtual page is held in the cache, the response appears in the cycle after acceptance, with `rsp_hit`=1 and `rsp_fault`=0.
- R3: When the virtual page misses the cache, the response appears two cycles after acceptance, with `rsp_hit`=0. If the page is resident, the translation is installed so that the next access to that page hits.
- R4: An access to a page whose map entry is not resident answers with `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr` all zeros. It installs nothing in the cache, so a repeat access again takes two cycles and faults.
- R5: Each cache slot has a recency counter. After reset the counters are the distinct values 0..N-1. An access that hits a slot or refills a slot sets that slot's counter to N-1 and decrements every counter that was above the slot's old value. A refill goes into the slot whose counter is 0.
- R6: A store that translates successfully, whether it hit or refilled, sets the page-map dirty bit of its page. Loads and faulting stores leave the dirty bit unchanged.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, the response pins hold steady and `req_ready`=0. `req_ready` is also 0 during the page-map read cycle.
- R8: Synchronous reset (`rst`=1 at a rising edge) empties the cache and clears every resident and dirty bit. After reset, `rsp_valid`=0 and `req_ready`=1.
- R9: A page-map write sets the entry's page number and resident bit, clears its dirty bit, and drops any cached copy of that virtual page. The next access to that page then misses and returns the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | VPN_W+OFS_W | Virtual byte address |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PPN_W+OFS_W | Physical byte address (zero on fault) |
| rsp_hit | output | 1 | Translation came from the cache |
| rsp_fault | output | 1 | Page not resident |
| map_wr_en | input | 1 | Write one page-map entry |
| map_wr_vpn | input | VPN_W | Entry to write |
| map_wr_ppn | input | PPN_W | Physical page number to store |
| map_wr_res | input | 1 | Resident bit to store |
| mon_vpn | input | VPN_W | Entry to show on the monitor pins |
| mon_res | output | 1 | Resident bit of the monitored entry |
| mon_dirty | output | 1 | Dirty bit of the monitored entry |
| mon_ppn | output | PPN_W | Physical page number of the monitored entry |

## Verification
The hardest state to reach is eviction order under a full cache. Which slot a refill replaces depends on the whole history of hits and refills, and nothing at the pins shows the counters. The bench keeps its own model of the recency rule. It fills all four slots, touches some of them again to reorder the counters, and then brings in new pages. After that it probes each older page: whether the probe answers in one cycle or two shows which page was evicted. Remapping a page that is already cached, and stalling a hit response with `rsp_ready` low, are reached the same way: by preparing the cached state first with ordinary accesses.

// File: rtl/vm_xlate_pkg.sv
`timescale 1ns/1ps
package vm_xlate_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xl_state_e;
endpackage

// File: rtl/vm_pagemap.sv
`timescale 1ns/1ps
module vm_pagemap #(
  parameter int VPN_W = 3,
  parameter int PPN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_res,
  input  logic             dset_en,
  input  logic [VPN_W-1:0] dset_vpn,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_res,
  output logic             rd_dirty,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic [VPN_W-1:0] mon_vpn,
  output logic             mon_res,
  output logic             mon_dirty,
  output logic [PPN_W-1:0] mon_ppn
);
  localparam int NENT = 1 << VPN_W;

  logic             res_q   [NENT];
  logic             dirty_q [NENT];
  logic [PPN_W-1:0] ppn_q   [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        ppn_q[i]   <= '0;
      end else if (wr_en && wr_vpn == VPN_W'(i)) begin
        // a software write always wins over a dirty update in the same cycle
        res_q[i]   <= wr_res;
        dirty_q[i] <= 1'b0;
        ppn_q[i]   <= wr_ppn;
      end else if (dset_en && dset_vpn == VPN_W'(i)) begin
        dirty_q[i] <= 1'b1;
      end
    end
  end

  assign rd_res    = res_q[rd_vpn];
  assign rd_dirty  = dirty_q[rd_vpn];
  assign rd_ppn    = ppn_q[rd_vpn];
  assign mon_res   = res_q[mon_vpn];
  assign mon_dirty = dirty_q[mon_vpn];
  assign mon_ppn   = ppn_q[mon_vpn];
endmodule

// File: rtl/vm_lru.sv
`timescale 1ns/1ps
module vm_lru #(
  parameter int NSLOT = 4,
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] TOP = IW'(NSLOT - 1);

  logic [IW-1:0] cnt_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[i] <= IW'(i);
      end else if (touch_en) begin
        if (touch_idx == IW'(i)) begin
          cnt_q[i] <= TOP;
        end else if (cnt_q[i] > cnt_q[touch_idx]) begin
          cnt_q[i] <= cnt_q[i] - 1'b1;
        end
      end
    end
  end

  // counters stay a permutation, so exactly one slot holds zero
  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < NSLOT; j++) begin
      if (cnt_q[j] == '0) victim_idx = IW'(j);
    end
  end
endmodule

// File: rtl/vm_tlb.sv
`timescale 1ns/1ps
module vm_tlb #(
  parameter int NSLOT = 4,
  parameter int VPN_W = 3,
  parameter int PPN_W = 2,
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IW-1:0]    lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             dset_en,
  input  logic [IW-1:0]    dset_idx,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic             v_q   [NSLOT];
  logic [VPN_W-1:0] tag_q [NSLOT];
  logic [PPN_W-1:0] ppn_q [NSLOT];
  logic             d_q   [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic             fill_here;
    logic [VPN_W-1:0] tag_next;
    assign fill_here = fill_en && fill_idx == IW'(i);
    assign tag_next  = fill_here ? fill_vpn : tag_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[i]   <= 1'b0;
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
        d_q[i]   <= 1'b0;
      end else begin
        if (fill_here) begin
          v_q[i]   <= 1'b1;
          tag_q[i] <= fill_vpn;
          ppn_q[i] <= fill_ppn;
          d_q[i]   <= fill_dirty;
        end else if (dset_en && dset_idx == IW'(i)) begin
          d_q[i] <= 1'b1;
        end
        // a map rewrite kills a copy even if it is being installed now
        if (inv_en && tag_next == inv_vpn) v_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_hit   = 1'b0;
    lk_idx   = '0;
    lk_ppn   = '0;
    lk_dirty = 1'b0;
    for (int j = 0; j < NSLOT; j++) begin
      if (v_q[j] && tag_q[j] == lk_vpn) begin
        lk_hit   = 1'b1;
        lk_idx   = IW'(j);
        lk_ppn   = ppn_q[j];
        lk_dirty = d_q[j];
      end
    end
  end
endmodule

// File: rtl/vm_xlate.sv
`timescale 1ns/1ps
module vm_xlate #(
  parameter int VPN_W = 3,
  parameter int PPN_W = 2,
  parameter int OFS_W = 4,
  parameter int NSLOT = 4,
  localparam int VA_W = VPN_W + OFS_W,
  localparam int PA_W = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_fault,
  input  logic             map_wr_en,
  input  logic [VPN_W-1:0] map_wr_vpn,
  input  logic [PPN_W-1:0] map_wr_ppn,
  input  logic             map_wr_res,
  input  logic [VPN_W-1:0] mon_vpn,
  output logic             mon_res,
  output logic             mon_dirty,
  output logic [PPN_W-1:0] mon_ppn
);
  import vm_xlate_pkg::*;
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  xl_state_e        state_q;
  logic [VPN_W-1:0] wvpn_q;
  logic [OFS_W-1:0] wofs_q;
  logic             wst_q;

  logic [VPN_W-1:0] req_vpn;
  logic [OFS_W-1:0] req_ofs;
  logic             accept, hit_take, walk, walk_ok;
  logic             lk_hit, lk_dirty;
  logic [IW-1:0]    lk_idx, victim;
  logic [PPN_W-1:0] lk_ppn, rd_ppn;
  logic             rd_res, rd_dirty;
  logic             map_dset;
  logic [VPN_W-1:0] map_dset_vpn;

  assign req_vpn   = req_vaddr[VA_W-1:OFS_W];
  assign req_ofs   = req_vaddr[OFS_W-1:0];
  assign req_ready = (state_q == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign hit_take  = accept && lk_hit;
  assign walk      = (state_q == ST_WALK);
  assign walk_ok   = walk && rd_res;

  // only the first store to a clean cached page needs the map update
  assign map_dset     = (hit_take && req_store && !lk_dirty) || (walk_ok && wst_q);
  assign map_dset_vpn = walk ? wvpn_q : req_vpn;

  vm_tlb #(.NSLOT(NSLOT), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk        (clk),
    .rst        (rst),
    .lk_vpn     (req_vpn),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .lk_ppn     (lk_ppn),
    .lk_dirty   (lk_dirty),
    .fill_en    (walk_ok),
    .fill_idx   (victim),
    .fill_vpn   (wvpn_q),
    .fill_ppn   (rd_ppn),
    .fill_dirty (rd_dirty | wst_q),
    .dset_en    (hit_take && req_store),
    .dset_idx   (lk_idx),
    .inv_en     (map_wr_en),
    .inv_vpn    (map_wr_vpn)
  );

  vm_lru #(.NSLOT(NSLOT)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (hit_take || walk_ok),
    .touch_idx  (walk ? victim : lk_idx),
    .victim_idx (victim)
  );

  vm_pagemap #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (map_wr_en),
    .wr_vpn    (map_wr_vpn),
    .wr_ppn    (map_wr_ppn),
    .wr_res    (map_wr_res),
    .dset_en   (map_dset),
    .dset_vpn  (map_dset_vpn),
    .rd_vpn    (wvpn_q),
    .rd_res    (rd_res),
    .rd_dirty  (rd_dirty),
    .rd_ppn    (rd_ppn),
    .mon_vpn   (mon_vpn),
    .mon_res   (mon_res),
    .mon_dirty (mon_dirty),
    .mon_ppn   (mon_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wvpn_q    <= '0;
      wofs_q    <= '0;
      wst_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else if (walk) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b1;
      rsp_hit   <= 1'b0;
      rsp_fault <= !rd_res;
      rsp_paddr <= rd_res ? {rd_ppn, wofs_q} : '0;
    end else if (accept) begin
      if (lk_hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_fault <= 1'b0;
        rsp_paddr <= {lk_ppn, req_ofs};
      end else begin
        rsp_valid <= 1'b0;
        state_q   <= ST_WALK;
        wvpn_q    <= req_vpn;
        wofs_q    <= req_ofs;
        wst_q     <= req_store;
      end
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vm_xlate_chk.sv
`timescale 1ns/1ps
module vm_xlate_chk #(
  parameter int OFS_W = 4,
  parameter int PA_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFS_W-1:0] req_ofs,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_hit,
  input logic             rsp_fault
);
  logic             pend_q;
  logic [1:0]       wait_q;
  logic [OFS_W-1:0] ofs_q;
  logic             rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wait_q <= '0;
      ofs_q  <= '0;
    end else if (req_valid && req_ready) begin
      pend_q <= 1'b1;
      wait_q <= '0;
      ofs_q  <= req_ofs;
    end else if (pend_q && rsp_valid) begin
      pend_q <= 1'b0;
    end else if (pend_q && wait_q != 2'd3) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_fault));

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_hit);

  assert_offset_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFS_W-1:0] == ofs_q);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    wait_q <= 2'd1);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> pend_q);

  assert_reset_R8: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !rsp_valid && req_ready);
endmodule

bind vm_xlate vm_xlate_chk #(.OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ofs   (req_vaddr[OFS_W-1:0]),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault)
);

// File: tb/test_vm_xlate.sv
`timescale 1ns/1ps
module test_vm_xlate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [6:0] req_vaddr = '0;
  logic       rsp_valid, rsp_ready = 1'b1, rsp_hit, rsp_fault;
  logic [5:0] rsp_paddr;
  logic       map_wr_en = 1'b0, map_wr_res = 1'b0;
  logic [2:0] map_wr_vpn = '0, mon_vpn = '0, mon_vpn_unused;
  logic [1:0] map_wr_ppn = '0, mon_ppn;
  logic       mon_res, mon_dirty;

  int nchk = 0, nfail = 0;

  // bench model of the requirements
  bit m_res[8]; int m_ppn[8]; bit m_dirty[8];
  bit t_v[4]; int t_vpn[4]; int t_cnt[4];

  always #2.5 clk = ~clk;
  assign mon_vpn_unused = mon_vpn;

  vm_xlate i_vm_xlate (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .map_wr_en(map_wr_en), .map_wr_vpn(map_wr_vpn), .map_wr_ppn(map_wr_ppn), .map_wr_res(map_wr_res),
    .mon_vpn(mon_vpn), .mon_res(mon_res), .mon_dirty(mon_dirty), .mon_ppn(mon_ppn)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < 8; j++) begin m_res[j] = 0; m_dirty[j] = 0; m_ppn[j] = 0; end
    for (int j = 0; j < 4; j++) begin t_v[j] = 0; t_vpn[j] = 0; t_cnt[j] = j; end
  endtask

  task automatic model_touch(input int k);
    int old;
    old = t_cnt[k];
    for (int j = 0; j < 4; j++) if (j != k && t_cnt[j] > old) t_cnt[j]--;
    t_cnt[k] = 3;
  endtask

  // computes expected response and advances the model
  task automatic model_access(input int va, input bit st,
                              output int elat, output int ehit, output int efault, output int epa);
    int vpn, ofs, hk;
    vpn = va >> 4; ofs = va & 15; hk = -1;
    for (int j = 0; j < 4; j++) if (t_v[j] && t_vpn[j] == vpn) hk = j;
    if (hk >= 0) begin
      elat = 1; ehit = 1; efault = 0; epa = (m_ppn[vpn] << 4) | ofs;
      if (st) m_dirty[vpn] = 1;
      model_touch(hk);
    end else begin
      elat = 2; ehit = 0;
      if (m_res[vpn]) begin
        int vic;
        vic = 0;
        for (int j = 0; j < 4; j++) if (t_cnt[j] == 0) vic = j;
        t_v[vic] = 1; t_vpn[vic] = vpn;
        model_touch(vic);
        if (st) m_dirty[vpn] = 1;
        efault = 0; epa = (m_ppn[vpn] << 4) | ofs;
      end else begin
        efault = 1; epa = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
  endtask

  task automatic map_write(input int vpn, input int ppn, input bit res);
    @(negedge clk);
    map_wr_en = 1'b1; map_wr_vpn = 3'(vpn); map_wr_ppn = 2'(ppn); map_wr_res = res;
    @(posedge clk); #1 map_wr_en = 1'b0;
    m_res[vpn] = res; m_ppn[vpn] = ppn; m_dirty[vpn] = 0;
    for (int j = 0; j < 4; j++) if (t_v[j] && t_vpn[j] == vpn) t_v[j] = 0;
  endtask

  task automatic access(input int va, input bit st, input string tag);
    int elat, ehit, efault, epa, lat;
    model_access(va, st, elat, ehit, efault, epa);
    @(negedge clk);
    chk(tag, "req_ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = 7'(va); req_store = st;
    @(posedge clk); #1 req_valid = 1'b0;
    if (rsp_valid) lat = 1;
    else begin
      @(posedge clk); #1;
      lat = rsp_valid ? 2 : 3;
    end
    chk(tag, "latency", lat, elat);
    chk(tag, "hit", int'(rsp_hit), ehit);
    chk(tag, "fault", int'(rsp_fault), efault);
    chk(tag, "paddr", int'(rsp_paddr), epa);
  endtask

  task automatic mon_check(input int vpn, input string tag);
    @(negedge clk); mon_vpn = 3'(vpn); #1;
    chk(tag, "monitor resident", int'(mon_res), int'(m_res[vpn]));
    chk(tag, "monitor dirty", int'(mon_dirty), int'(m_dirty[vpn]));
    if (m_res[vpn]) chk(tag, "monitor ppn", int'(mon_ppn), m_ppn[vpn]);
  endtask

  task automatic load_table();
    map_write(0, 3, 1); map_write(1, 0, 1); map_write(2, 1, 1); map_write(3, 2, 0);
    map_write(4, 2, 1); map_write(5, 3, 1); map_write(6, 0, 0); map_write(7, 1, 1);
  endtask

  task automatic t_reset_state();   // R8
    @(negedge clk);
    chk("R8", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R8", "req_ready after reset", int'(req_ready), 1);
    for (int v = 0; v < 8; v++) mon_check(v, "R8");
  endtask

  task automatic t_miss_then_hit(); // R1 R2 R3
    access('h27, 0, "R3");  // vpn 2 cold miss
    access('h2A, 0, "R2");  // same page hits, new offset (R1)
    access('h4F, 0, "R3");
    access('h40, 0, "R1");
  endtask

  task automatic t_fault();         // R4
    access('h35, 0, "R4");
    access('h35, 1, "R4");          // repeat still faults, store leaves dirty alone
    mon_check(3, "R4");
  endtask

  task automatic t_lru();           // R5
    do_reset(); load_table();
    access('h01, 0, "R5"); access('h11, 0, "R5");
    access('h21, 0, "R5"); access('h41, 0, "R5");
    access('h02, 0, "R5");          // re-touch vpn 0, vpn 1 now oldest
    access('h51, 0, "R5");          // evicts vpn 1
    access('h71, 0, "R5");          // evicts vpn 2
    access('h03, 0, "R5");          // vpn 0 still cached
    access('h13, 0, "R5");          // vpn 1 was evicted
    access('h23, 0, "R5");          // vpn 2 was evicted
    access('h5C, 0, "R5");
  endtask

  task automatic t_dirty();         // R6
    access('h5D, 1, "R6");          // store hit on vpn 5
    mon_check(5, "R6");
    access('h7E, 0, "R6");          // load leaves clean
    mon_check(7, "R6");
    map_write(4, 2, 1);
    access('h44, 1, "R6");          // store refill
    mon_check(4, "R6");
  endtask

  task automatic t_backpressure();  // R7
    int elat, ehit, efault, epa;
    logic [5:0] held;
    model_access('h49, 0, elat, ehit, efault, epa);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = 7'h49; req_store = 1'b0;
    @(posedge clk); #1 req_valid = 1'b0;
    chk("R7", "stalled rsp_valid", int'(rsp_valid), 1);
    chk("R7", "stalled paddr", int'(rsp_paddr), epa);
    held = rsp_paddr;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R7", "held valid", int'(rsp_valid), 1);
      chk("R7", "held paddr", int'(rsp_paddr), int'(held));
      chk("R7", "req_ready while stalled", int'(req_ready), 0);
    end
    @(negedge clk) rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R7", "rsp dropped after take", int'(rsp_valid), 0);
  endtask

  task automatic t_remap();         // R9
    map_write(5, 1, 1);             // vpn 5 is cached and dirty
    mon_check(5, "R9");
    access('h56, 0, "R9");          // must miss and return new page
    access('h56, 0, "R9");
  endtask

  task automatic t_mid_reset();     // R8
    do_reset();
    mon_check(4, "R8");
    access('h43, 0, "R8");          // no resident pages: fault
  endtask

  initial begin
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    load_table();
    t_miss_then_hit();
    t_fault();
    t_lru();
    t_dirty();
    t_backpressure();
    t_remap();
    t_mid_reset();
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule